// File: doc/BRIEF.md
# Transmit Descriptor and Address-Filter Setup Engine

This block is the device side of a transmit path that works from a ring of descriptors in shared memory. The host prepares a descriptor, hands it over by setting its ownership bit and pulses the poll-demand input. The engine then reads the descriptor's status word. When it owns the descriptor, it reads the control and buffer-pointer words and acts on them. An ordinary frame is fetched one 32-bit word at a time and sent out, one byte per handshake, on a byte stream with first and last markers. A descriptor marked as a setup frame is not sent. Its buffer is parsed into a table of sixteen 48-bit station addresses, which a separate compare port searches for a perfect match.

After each descriptor the engine writes a completion status into the descriptor's first word, which also returns ownership to the host. It then moves on to the next descriptor in the ring and keeps going until it meets one it does not own. An input that enables transmission gates the whole engine. Framing, padding and CRC belong to the MAC beyond the byte port.

Descriptor layout, in 32-bit words starting at the descriptor base: word 0 is status, word 1 is control, word 2 is the buffer word address, and word 3 is unused. Descriptors sit four words apart. Buffer bytes are packed little-endian within each word.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset, and while `txEnable` is low, `procState` is 0 and `txValid`, `memRd` and `memWr` are low. After reset the address table holds all-ones in every entry, so `matchHit` is 1 for FF:FF:FF:FF:FF:FF and 0 for any other address.
- R2: With `txEnable` high, a `pollDemand` pulse makes the engine read word 0 of the current descriptor. If bit 31 (ownership) is 0, the engine writes nothing, sends nothing and goes to the suspended state.
- R3: For an owned descriptor whose control bit 27 is 0, the engine sends exactly the number of bytes given by control bits 11:0. Bytes go in buffer order, with byte k taken from bits 8*(k%4)+7:8*(k%4) of buffer word k/4. `txFirst` is set on the first byte only, and only if control bit 29 is 1. `txLast` is set on the final byte only, and only if control bit 30 is 1.
- R4: When an ordinary frame completes, the only memory write is status word 0 of that descriptor, with the value 0x00000000 (bit 31 cleared).
- R5: A descriptor whose length field (bits 11:0) is 0 or greater than 2047 sends no bytes and completes with status 0x00008000 (bit 15 is the error summary). A length of exactly 2047 is sent normally.
- R6: An owned descriptor with control bit 27 set and a length of 192 sends no bytes. It loads the 48 buffer words into the 16-entry table and completes with status 0x7FFFFFFF. Entry e uses words 3e, 3e+1 and 3e+2. Only the low 16 bits of each word are used: bits 7:0 give the earlier address octet and bits 15:8 the later one. The first octet lands in address bits 47:40.
- R7: A descriptor with bit 27 set and a length other than 192 completes with status 0x00008000 and leaves the table unchanged.
- R8: `matchHit` is 1 exactly when `matchAddr` equals one of the 16 table entries.
- R9: After completing a descriptor, the engine moves to the next one, four words on. If control bit 25 (end of ring) was set, it returns to `ringBase` instead. It processes every following owned descriptor without a new poll and suspends at the first one it does not own.
- R10: While `txValid` is high and `txReady` is low, `txValid`, `txData`, `txFirst` and `txLast` hold their values.
- R11: `procState` reads 0 when stopped, 1 while fetching a descriptor, 2 while moving frame data, 5 while loading the table, 7 while writing status back, and 6 when suspended. No other value appears.
- R12: While `txEnable` is low, `pollDemand` is ignored and the descriptor pointer is returned to `ringBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmit enable from the mode register |
| pollDemand | input | 1 | One-cycle pulse from the poll-demand register |
| ringBase | input | AW | Word address of descriptor 0 |
| memRd | output | 1 | Memory read request; data is expected one cycle later |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | AW | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid the cycle after `memRd` |
| txValid | output | 1 | Byte stream valid |
| txReady | input | 1 | Byte stream ready |
| txData | output | 8 | Byte stream data |
| txFirst | output | 1 | First byte of the frame |
| txLast | output | 1 | Last byte of the frame |
| matchAddr | input | 48 | Destination address to search, first octet in bits 47:40 |
| matchHit | output | 1 | Perfect-match result |
| procState | output | 3 | Transmit process state code |

## Verification
The bench aims at the edges of the length field. Lengths 0 and 2500 must give the error status and no bytes; a design that checked only for zero, or truncated to 11 bits, would send a frame instead. A length of 2047 must still go out in full. Ring wrap is exercised by running frames past the descriptor marked end-of-ring; a design that ignored that bit would fetch an unowned slot and leave the frame unsent. A chained pair sent on a single poll catches an engine that stops after one descriptor. Setup frames of the right and the wrong length check that table octets are placed in the right order, that no bytes leak onto the stream, and that a rejected setup does not corrupt earlier entries. A held-off `txReady` catches data that moves while stalled.

// File: rtl/txeng_pkg.sv
package txeng_pkg;
  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 30;
  localparam int FIRST_BIT = 29;
  localparam int SETUP_BIT = 27;
  localparam int EOR_BIT   = 25;
  localparam int ERR_BIT   = 15;

  localparam logic [31:0] STATUS_DONE  = 32'h0;
  localparam logic [31:0] STATUS_FAULT = 32'h1 << ERR_BIT;
  localparam logic [31:0] STATUS_SETUP = ~(32'h1 << OWN_BIT);

  typedef enum logic [1:0] {SEL_STAT, SEL_CTRL, SEL_BUFADR, SEL_DATA} addr_sel_t;
  typedef enum logic [1:0] {WB_DONE, WB_FAULT, WB_SETUP} wb_kind_t;

  typedef enum logic [3:0] {
    ST_STOP, ST_SUSP, ST_RSTAT, ST_CSTAT, ST_RCTRL, ST_CCTRL, ST_RBUF, ST_CBUF,
    ST_RDATA, ST_CDATA, ST_EMIT, ST_RSET, ST_CSET, ST_WB
  } state_t;

  typedef struct packed {
    addr_sel_t addrSel;
    wb_kind_t  wbKind;
    logic      ldCtrl;
    logic      ldBuf;
    logic      ldWord;
    logic      popByte;
    logic      ldHalf;
    logic      nextDesc;
    logic      rstPtr;
  } strobe_t;

  typedef struct packed {
    logic owned;
    logic setupFlag;
    logic lenBad;
    logic setupLenOk;
    logic lastByte;
    logic wordEnd;
    logic tableEnd;
  } flags_t;
endpackage

// File: rtl/txeng_ctrl.sv
module txeng_ctrl
  import txeng_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txEnable,
  input  logic         pollDemand,
  input  logic         txReady,
  input  flags_t       flg,
  output strobe_t      str,
  output logic         memRd,
  output logic         memWr,
  output logic         txValid,
  output logic [2:0]   procState
);
  state_t   st, stNext;
  wb_kind_t kind, kindNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_STOP;
      kind <= WB_DONE;
    end else begin
      st   <= stNext;
      kind <= kindNext;
    end
  end

  always_comb begin
    stNext      = st;
    kindNext    = kind;
    str         = '0;
    str.addrSel = SEL_STAT;
    str.wbKind  = kind;
    memRd       = 1'b0;
    memWr       = 1'b0;
    txValid     = 1'b0;
    case (st)
      ST_STOP: begin
        str.rstPtr = 1'b1;
        if (txEnable) stNext = ST_SUSP;
      end
      ST_SUSP: begin
        if (!txEnable)      stNext = ST_STOP;
        else if (pollDemand) stNext = ST_RSTAT;
      end
      ST_RSTAT: begin
        memRd  = 1'b1;
        stNext = ST_CSTAT;
      end
      ST_CSTAT: stNext = flg.owned ? ST_RCTRL : ST_SUSP;
      ST_RCTRL: begin
        memRd       = 1'b1;
        str.addrSel = SEL_CTRL;
        stNext      = ST_CCTRL;
      end
      ST_CCTRL: begin
        str.ldCtrl = 1'b1;
        stNext     = ST_RBUF;
      end
      ST_RBUF: begin
        memRd       = 1'b1;
        str.addrSel = SEL_BUFADR;
        stNext      = ST_CBUF;
      end
      ST_CBUF: begin
        str.ldBuf = 1'b1;
        if (flg.lenBad || (flg.setupFlag && !flg.setupLenOk)) begin
          kindNext = WB_FAULT;
          stNext   = ST_WB;
        end else if (flg.setupFlag) begin
          stNext = ST_RSET;
        end else begin
          stNext = ST_RDATA;
        end
      end
      ST_RDATA: begin
        memRd       = 1'b1;
        str.addrSel = SEL_DATA;
        stNext      = ST_CDATA;
      end
      ST_CDATA: begin
        str.ldWord = 1'b1;
        stNext     = ST_EMIT;
      end
      ST_EMIT: begin
        txValid = 1'b1;
        if (txReady) begin
          str.popByte = 1'b1;
          if (flg.lastByte) begin
            kindNext = WB_DONE;
            stNext   = ST_WB;
          end else if (flg.wordEnd) begin
            stNext = ST_RDATA;
          end
        end
      end
      ST_RSET: begin
        memRd       = 1'b1;
        str.addrSel = SEL_DATA;
        stNext      = ST_CSET;
      end
      ST_CSET: begin
        str.ldHalf = 1'b1;
        if (flg.tableEnd) begin
          kindNext = WB_SETUP;
          stNext   = ST_WB;
        end else begin
          stNext = ST_RSET;
        end
      end
      ST_WB: begin
        memWr        = 1'b1;
        str.nextDesc = 1'b1;
        stNext       = txEnable ? ST_RSTAT : ST_STOP;
      end
      default: stNext = ST_STOP;
    endcase
  end

  always_comb begin
    case (st)
      ST_STOP:                    procState = 3'd0;
      ST_SUSP:                    procState = 3'd6;
      ST_RDATA, ST_CDATA, ST_EMIT: procState = 3'd2;
      ST_RSET, ST_CSET:           procState = 3'd5;
      ST_WB:                      procState = 3'd7;
      default:                    procState = 3'd1;
    endcase
  end
endmodule

// File: rtl/txeng_dpath.sv
module txeng_dpath
  import txeng_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LW       = 12,
  parameter int MAXLEN   = 2047,
  parameter int SETUPLEN = 192,
  parameter int ENTRIES  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [AW-1:0]              ringBase,
  input  logic [31:0]                memRdata,
  input  strobe_t                    str,
  output flags_t                     flg,
  output logic [AW-1:0]              memAddr,
  output logic [31:0]                memWdata,
  output logic [7:0]                 txData,
  output logic                       txFirst,
  output logic                       txLast,
  output logic                       tblWr,
  output logic [$clog2(ENTRIES)-1:0] tblEntry,
  output logic [1:0]                 tblSlot,
  output logic [15:0]                tblHalf
);
  localparam int EW = $clog2(ENTRIES);

  logic [AW-1:0] curDesc, bufPtr;
  logic [LW-1:0] lenField, remain;
  logic          fLast, fFirst, fSetup, fEor, firstPend;
  logic [31:0]   wordBuf;
  logic [1:0]    byteIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc   <= '0;
      bufPtr    <= '0;
      lenField  <= '0;
      remain    <= '0;
      {fLast, fFirst, fSetup, fEor} <= '0;
      firstPend <= 1'b0;
      wordBuf   <= '0;
      byteIdx   <= '0;
      tblEntry  <= '0;
      tblSlot   <= '0;
    end else begin
      if (str.rstPtr) curDesc <= ringBase;
      else if (str.nextDesc) curDesc <= fEor ? ringBase : curDesc + AW'(4);
      if (str.ldCtrl) begin
        lenField <= memRdata[LW-1:0];
        remain   <= memRdata[LW-1:0];
        fLast    <= memRdata[LAST_BIT];
        fFirst   <= memRdata[FIRST_BIT];
        fSetup   <= memRdata[SETUP_BIT];
        fEor     <= memRdata[EOR_BIT];
      end
      if (str.ldBuf) begin
        bufPtr    <= memRdata[AW-1:0];
        byteIdx   <= '0;
        firstPend <= 1'b1;
        tblEntry  <= '0;
        tblSlot   <= '0;
      end
      if (str.ldWord) begin
        wordBuf <= memRdata;
        bufPtr  <= bufPtr + AW'(1);
      end
      if (str.popByte) begin
        remain    <= remain - LW'(1);
        byteIdx   <= byteIdx + 2'd1;
        firstPend <= 1'b0;
      end
      if (str.ldHalf) begin
        bufPtr <= bufPtr + AW'(1);
        if (tblSlot == 2'd2) begin
          tblSlot  <= '0;
          tblEntry <= tblEntry + EW'(1);
        end else begin
          tblSlot <= tblSlot + 2'd1;
        end
      end
    end
  end

  always_comb begin
    case (str.addrSel)
      SEL_STAT:   memAddr = curDesc;
      SEL_CTRL:   memAddr = curDesc + AW'(1);
      SEL_BUFADR: memAddr = curDesc + AW'(2);
      default:    memAddr = bufPtr;
    endcase
    case (str.wbKind)
      WB_FAULT: memWdata = STATUS_FAULT;
      WB_SETUP: memWdata = STATUS_SETUP;
      default:  memWdata = STATUS_DONE;
    endcase
  end

  assign flg.owned      = memRdata[OWN_BIT];
  assign flg.setupFlag  = fSetup;
  assign flg.lenBad     = (lenField == '0) || (lenField > LW'(MAXLEN));
  assign flg.setupLenOk = (lenField == LW'(SETUPLEN));
  assign flg.lastByte   = (remain == LW'(1));
  assign flg.wordEnd    = (byteIdx == 2'd3);
  assign flg.tableEnd   = (tblEntry == EW'(ENTRIES - 1)) && (tblSlot == 2'd2);

  assign txData  = wordBuf[{byteIdx, 3'b000} +: 8];
  assign txFirst = fFirst && firstPend;
  assign txLast  = fLast && (remain == LW'(1));
  assign tblWr   = str.ldHalf;
  assign tblHalf = memRdata[15:0];
endmodule

// File: rtl/txeng_filter.sv
module txeng_filter #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tblWr,
  input  logic [$clog2(ENTRIES)-1:0] tblEntry,
  input  logic [1:0]                 tblSlot,
  input  logic [15:0]                tblHalf,
  input  logic [47:0]                matchAddr,
  output logic                       matchHit
);
  logic [ENTRIES-1:0] hitVec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [47:0] addrReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrReg <= '1;
      end else if (tblWr && (tblEntry == e)) begin
        case (tblSlot)
          2'd0:    addrReg[47:32] <= {tblHalf[7:0], tblHalf[15:8]};
          2'd1:    addrReg[31:16] <= {tblHalf[7:0], tblHalf[15:8]};
          default: addrReg[15:0]  <= {tblHalf[7:0], tblHalf[15:8]};
        endcase
      end
    end
    assign hitVec[e] = (addrReg == matchAddr);
  end

  assign matchHit = |hitVec;
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
  import txeng_pkg::*;
#(
  parameter int AW      = 16,
  parameter int LW      = 12,
  parameter int MAXLEN  = 2047,
  parameter int ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txEnable,
  input  logic          pollDemand,
  input  logic [AW-1:0] ringBase,
  output logic          memRd,
  output logic          memWr,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          txValid,
  input  logic          txReady,
  output logic [7:0]    txData,
  output logic          txFirst,
  output logic          txLast,
  input  logic [47:0]   matchAddr,
  output logic          matchHit,
  output logic [2:0]    procState
);
  localparam int SETUPLEN = ENTRIES * 12;
  localparam int EW       = $clog2(ENTRIES);

  strobe_t         str;
  flags_t          flg;
  logic            tblWr;
  logic [EW-1:0]   tblEntry;
  logic [1:0]      tblSlot;
  logic [15:0]     tblHalf;

  txeng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .pollDemand(pollDemand),
    .txReady(txReady), .flg(flg), .str(str), .memRd(memRd), .memWr(memWr),
    .txValid(txValid), .procState(procState)
  );

  txeng_dpath #(
    .AW(AW), .LW(LW), .MAXLEN(MAXLEN), .SETUPLEN(SETUPLEN), .ENTRIES(ENTRIES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .memRdata(memRdata),
    .str(str), .flg(flg), .memAddr(memAddr), .memWdata(memWdata),
    .txData(txData), .txFirst(txFirst), .txLast(txLast), .tblWr(tblWr),
    .tblEntry(tblEntry), .tblSlot(tblSlot), .tblHalf(tblHalf)
  );

  txeng_filter #(.ENTRIES(ENTRIES)) u_filter (
    .clk(clk), .rstN(rstN), .tblWr(tblWr), .tblEntry(tblEntry),
    .tblSlot(tblSlot), .tblHalf(tblHalf), .matchAddr(matchAddr),
    .matchHit(matchHit)
  );
endmodule

// File: rtl/txeng_checker.sv
module txeng_checker (
  input logic        clk,
  input logic        rstN,
  input logic        memRd,
  input logic        memWr,
  input logic [31:0] memWdata,
  input logic        txValid,
  input logic        txReady,
  input logic [7:0]  txData,
  input logic        txFirst,
  input logic        txLast,
  input logic [2:0]  procState
);
  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_own_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> !memWdata[31]);

  assert_status_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (memWdata == 32'h0 || memWdata == 32'h0000_8000 || memWdata == 32'h7FFF_FFFF));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txFirst) && $stable(txLast)));

  assert_stopped_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (procState == 3'd0) |-> (!memRd && !memWr && !txValid));

  assert_valid_in_xfer_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (procState == 3'd2));

  assert_state_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    procState inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6, 3'd7});
endmodule

bind tx_desc_engine txeng_checker u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
  .txValid(txValid), .txReady(txReady), .txData(txData), .txFirst(txFirst),
  .txLast(txLast), .procState(procState)
);

// File: tb/tx_desc_engine_tb.sv
`timescale 1ns/1ps
module tx_desc_engine_tb;
  localparam int AW    = 16;
  localparam int RING  = 4;
  localparam int RBASE = 16'h0040;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          txEnable = 1'b0;
  logic          pollDemand = 1'b0;
  logic [AW-1:0] ringBase = AW'(RBASE);
  logic          memRd, memWr;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata;
  logic          txValid;
  logic          txReady = 1'b0;
  logic [7:0]    txData;
  logic          txFirst, txLast;
  logic [47:0]   matchAddr = '0;
  logic          matchHit;
  logic [2:0]    procState;

  tx_desc_engine u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .pollDemand(pollDemand),
    .ringBase(ringBase), .memRd(memRd), .memWr(memWr), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .txValid(txValid),
    .txReady(txReady), .txData(txData), .txFirst(txFirst), .txLast(txLast),
    .matchAddr(matchAddr), .matchHit(matchHit), .procState(procState)
  );

  logic [31:0] mem [4096];
  initial for (int i = 0; i < 4096; i++) mem[i] = '0;
  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr[11:0]];
    if (memWr) mem[memAddr[11:0]] <= memWdata;
  end

  int readyMode = 1;
  initial forever begin
    @(posedge clk); #1;
    txReady = (readyMode == 1) ? 1'b1 : (readyMode == 0) ? 1'b0 : 1'($urandom % 2);
  end

  logic [7:0] capData[$];
  bit         capF[$], capL[$];
  logic [7:0] expB[$];
  always @(negedge clk) if (rstN && txValid && txReady) begin
    capData.push_back(txData); capF.push_back(txFirst); capL.push_back(txLast);
  end

  int nChecks = 0, nFails = 0, curIdx = 0;
  bit finished = 0;
  logic [47:0] setAddr [ENT_N];
  localparam int ENT_N = 16;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int descAddr(input int idx);
    return RBASE + 4 * idx;
  endfunction

  function automatic logic [31:0] ctrlWord(input int idx, input int len, input bit f,
                                           input bit l, input bit setup);
    return (32'(l) << 30) | (32'(f) << 29) | (32'(setup) << 27) |
           (32'(idx == RING - 1) << 25) | 32'(len & 12'hFFF);
  endfunction

  task automatic putDesc(input int idx, input logic [31:0] ctl, input int bufW);
    mem[descAddr(idx)]     <= 32'h8000_0000;
    mem[descAddr(idx) + 1] <= ctl;
    mem[descAddr(idx) + 2] <= 32'(bufW);
  endtask

  task automatic putFrame(input int idx, input int len, input bit f, input bit l, input int bufW);
    logic [31:0] w;
    for (int k = 0; k < (len + 3) / 4; k++) begin
      w = $urandom;
      mem[bufW + k] <= w;
      for (int b = 0; b < 4; b++) if (4 * k + b < len) expB.push_back(w[8*b +: 8]);
    end
    putDesc(idx, ctrlWord(idx, len, f, l, 1'b0), bufW);
  endtask

  task automatic poll();
    @(negedge clk) pollDemand = 1'b1;
    @(negedge clk) pollDemand = 1'b0;
  endtask

  task automatic waitSusp(input string tag);
    int n = 0;
    while (procState != 3'd6 && n < 6000) begin @(negedge clk); n++; end
    check(procState == 3'd6, tag, procState, 6);
  endtask

  task automatic clearCap();
    capData.delete(); capF.delete(); capL.delete(); expB.delete();
  endtask

  task automatic checkBytes(input string tag, input bit f, input bit l);
    bit same = (capData.size() == expB.size());
    bit flagsOk = 1;
    check(capData.size() == expB.size(), {tag, " count"}, capData.size(), expB.size());
    if (same) for (int i = 0; i < expB.size(); i++) if (capData[i] !== expB[i]) same = 0;
    check(same, {tag, " data"}, same, 1);
    for (int i = 0; i < capF.size(); i++) begin
      if (capF[i] != ((i == 0) && f)) flagsOk = 0;
      if (capL[i] != ((i == capF.size() - 1) && l)) flagsOk = 0;
    end
    check(flagsOk, {tag, " first/last"}, flagsOk, 1);
  endtask

  task automatic probe(input logic [47:0] a, output bit hit);
    @(negedge clk) matchAddr = a;
    #1 hit = matchHit;
  endtask

  initial begin
    int seedDummy;
    bit hit, allHit, held;
    logic [7:0] d0;
    logic [31:0] w;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state and default table
    check(procState == 0 && !txValid && !memRd && !memWr, "R1 reset outputs", procState, 0);
    probe(48'hFFFF_FFFF_FFFF, hit); check(hit, "R1 broadcast hit", hit, 1);
    probe(48'h0102_0304_0506, hit); check(!hit, "R8 reset miss", hit, 0);

    // R12: poll ignored while disabled
    clearCap();
    putFrame(0, 6, 1, 1, 16'h400);
    poll(); repeat (20) @(negedge clk);
    check(mem[descAddr(0)] == 32'h8000_0000, "R12 poll ignored status", mem[descAddr(0)], 32'h8000_0000);
    check(capData.size() == 0 && procState == 0, "R12 no bytes stopped", capData.size(), 0);

    // enable: the pending owned descriptor now goes on poll
    txEnable = 1'b1; repeat (3) @(negedge clk);
    check(procState == 6, "R11 suspended code", procState, 6);
    poll(); waitSusp("R3 frame0 done");
    checkBytes("R3 frame0", 1, 1);
    check(mem[descAddr(0)] == 32'h0, "R4 frame0 status", mem[descAddr(0)], 0);
    curIdx = 1;

    // R2: unowned descriptor
    clearCap();
    poll(); waitSusp("R2 unowned suspend");
    check(capData.size() == 0 && mem[descAddr(1)] == 32'h0, "R2 unowned untouched", capData.size(), 0);

    // R3, R9: random frames through the wrap, random ready
    readyMode = 2;
    for (int t = 0; t < 8; t++) begin
      int len = 1 + ($urandom % 40);
      bit f = 1'($urandom % 2), l = 1'($urandom % 2);
      clearCap();
      putFrame(curIdx, len, f, l, 16'h400 + 16 * t);
      poll(); waitSusp("R9 random frame done");
      checkBytes($sformatf("R3 random frame %0d", t), f, l);
      check(mem[descAddr(curIdx)] == 32'h0, "R4 random status", mem[descAddr(curIdx)], 0);
      curIdx = (curIdx + 1) % RING;
    end

    // R9: two owned descriptors on one poll
    clearCap();
    putFrame(curIdx, 9, 1, 0, 16'h500);
    putFrame((curIdx + 1) % RING, 7, 0, 1, 16'h520);
    poll(); waitSusp("R9 chain done");
    check(capData.size() == 16, "R9 chain bytes", capData.size(), 16);
    check(mem[descAddr(curIdx)] == 0 && mem[descAddr((curIdx + 1) % RING)] == 0,
          "R9 chain statuses", mem[descAddr((curIdx + 1) % RING)], 0);
    curIdx = (curIdx + 2) % RING;
    readyMode = 1;

    // R10: backpressure hold
    readyMode = 0; clearCap();
    putFrame(curIdx, 8, 1, 1, 16'h540);
    poll();
    for (int n = 0; n < 50 && !txValid; n++) @(negedge clk);
    d0 = txData; held = txValid;
    repeat (5) @(negedge clk);
    check(held && txValid && txData == d0 && procState == 2, "R10 stalled data held", txData, d0);
    readyMode = 1; waitSusp("R10 release");
    checkBytes("R10 frame", 1, 1);
    curIdx = (curIdx + 1) % RING;

    // R5: bad lengths
    foreach (expB[i]) ;
    for (int t = 0; t < 2; t++) begin
      int len = (t == 0) ? 0 : 2500;
      clearCap();
      putDesc(curIdx, ctrlWord(curIdx, len, 1, 1, 0), 16'h600);
      poll(); waitSusp("R5 bad length done");
      check(mem[descAddr(curIdx)] == 32'h0000_8000, "R5 bad length status", mem[descAddr(curIdx)], 32'h8000);
      check(capData.size() == 0, "R5 bad length no bytes", capData.size(), 0);
      curIdx = (curIdx + 1) % RING;
    end
    clearCap();
    putFrame(curIdx, 2047, 1, 1, 16'h800);
    poll(); waitSusp("R5 max length done");
    checkBytes("R5 length 2047", 1, 1);
    check(mem[descAddr(curIdx)] == 32'h0, "R5 max length status", mem[descAddr(curIdx)], 0);
    curIdx = (curIdx + 1) % RING;

    // R6, R8: setup frame
    clearCap();
    for (int e = 0; e < ENT_N; e++) begin
      setAddr[e] = {16'($urandom), 32'($urandom)} & 48'hFEFF_FFFF_FFFF;
      for (int s = 0; s < 3; s++) begin
        w = {16'hFFFF, setAddr[e][39 - 16*s -: 8], setAddr[e][47 - 16*s -: 8]};
        mem[16'h700 + 3*e + s] <= w;
      end
    end
    putDesc(curIdx, ctrlWord(curIdx, 192, 0, 0, 1), 16'h700);
    poll(); waitSusp("R6 setup done");
    check(mem[descAddr(curIdx)] == 32'h7FFF_FFFF, "R6 setup status", mem[descAddr(curIdx)], 32'h7FFF_FFFF);
    check(capData.size() == 0, "R6 setup sends nothing", capData.size(), 0);
    allHit = 1;
    for (int e = 0; e < ENT_N; e++) begin probe(setAddr[e], hit); allHit &= hit; end
    check(allHit, "R8 all loaded entries hit", allHit, 1);
    probe(setAddr[3] ^ 48'h1, hit); check(!hit, "R8 near miss", hit, 0);
    probe(48'hFFFF_FFFF_FFFF, hit); check(!hit, "R6 broadcast replaced", hit, 0);
    curIdx = (curIdx + 1) % RING;

    // R7: setup with wrong length
    for (int k = 0; k < 48; k++) mem[16'h780 + k] <= 32'h0000_1111;
    putDesc(curIdx, ctrlWord(curIdx, 100, 0, 0, 1), 16'h780);
    poll(); waitSusp("R7 bad setup done");
    check(mem[descAddr(curIdx)] == 32'h0000_8000, "R7 bad setup status", mem[descAddr(curIdx)], 32'h8000);
    probe(setAddr[5], hit); check(hit, "R7 table unchanged", hit, 1);
    curIdx = (curIdx + 1) % RING;

    // R12: disable returns pointer to ring base
    if (curIdx == 0) begin
      clearCap(); putFrame(0, 4, 0, 0, 16'h560); poll(); waitSusp("R12 pad");
      curIdx = 1;
    end
    txEnable = 1'b0; repeat (4) @(negedge clk);
    check(procState == 0, "R11 stopped code", procState, 0);
    txEnable = 1'b1; repeat (2) @(negedge clk);
    clearCap();
    putFrame(0, 5, 1, 0, 16'h580);
    poll(); waitSusp("R12 restart done");
    checkBytes("R12 restart at ring base", 1, 0);
    check(mem[descAddr(0)] == 32'h0, "R12 restart status", mem[descAddr(0)], 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule